// File: doc/BRIEF.md
# Asynchronous Serial Receive Engine

This block turns an asynchronous serial input line into characters for a receive queue. It runs entirely from the system clock. A set of static configuration inputs selects the character width (5 to 8 bits), whether a parity bit is present and its sense, and whether one or two stop bits end a character. The bit period is given directly as a count of clock cycles. A second count, the sample offset, chooses the cycle inside each bit period at which the line is read. Software normally sets the offset to half the period, so each bit is read at its middle.

A falling edge on the synchronized line starts a character. The start bit is read again at the sample offset, and a high reading drops the attempt as noise. Data bits arrive least significant bit first. When the last stop bit has been read, the engine pushes the character toward the queue with a one-cycle write strobe, unless the queue reports full. In that case it pulses an overrun event and drops the character. Parity mismatches and low stop bits raise one-cycle error pulses. A character that is zero throughout, including its parity and first stop bit, is reported as a line break and is not pushed. After a break the engine stays parked until the line returns high.

Top module: `serial_rx_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_wr, ev_parity_err, ev_stop_err, ev_break and ev_overrun are all low.
- R2: Data bits are taken least significant first. cfg_width encodes the character width: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Bits of out_data above the width read as zero. Each accepted character produces exactly one out_wr pulse of one cycle.
- R3: A bit lasts cfg_divisor clock cycles. The line is read cfg_sample_off cycles into each bit period, measured from the synchronized falling edge of the start bit (legal range 1 to cfg_divisor-2, with cfg_divisor at least 4).
- R4: A character begins only on a falling edge of the synchronized line while idle. If the line reads high at the start bit's sample point, the engine returns to idle and produces no output.
- R5: With cfg_par_en = 1, one parity bit follows the data. cfg_par_even = 1 means data plus parity hold an even number of ones, and 0 means odd. A mismatch pulses ev_parity_err in the same cycle as the character's out_wr (or ev_overrun), and the character is still delivered.
- R6: With cfg_stop2 = 0 one stop bit is read; with cfg_stop2 = 1 two are read. If any of them reads low, ev_stop_err pulses and the character is still delivered.
- R7: A character whose data bits, parity bit (if enabled) and first stop bit are all zero is a break. It pulses ev_break together with ev_stop_err, produces no out_wr, and suppresses any parity error. No new character starts until the line has returned high.
- R8: If fifo_full is high in the cycle the last stop bit is read, the character is dropped and ev_overrun pulses instead of out_wr. out_wr and ev_overrun are never high together.
- R9: While en_global or en_rx is low, the engine is held idle and none of out_wr or the event outputs go high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_global | input | 1 | Global enable for the serial port |
| en_rx | input | 1 | Receive enable |
| cfg_width | input | 2 | Character width code (0..3 = 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_stop2 | input | 1 | 1 = two stop bits, 0 = one |
| cfg_divisor | input | DIV_W | Clock cycles per bit |
| cfg_sample_off | input | DIV_W | Sample cycle inside each bit |
| rxd | input | 1 | Asynchronous serial input, idles high |
| fifo_full | input | 1 | Receive queue cannot accept a character |
| out_data | output | 8 | Received character, zero-extended |
| out_wr | output | 1 | One-cycle push strobe toward the queue |
| ev_parity_err | output | 1 | Parity mismatch pulse |
| ev_stop_err | output | 1 | Low stop bit pulse |
| ev_break | output | 1 | Break detected pulse |
| ev_overrun | output | 1 | Character dropped because the queue was full |

## Verification
The hardest case to reach from the ports is proof that the programmed sample offset, and not some fixed midpoint, decides which part of each bit is read. The bench reaches it with a directed character whose bits hold one value for the first half of every period and the inverted value for the second half. It receives that character once with an early offset and once with a late one, and expects the true byte from the first run and its complement from the second. Break recovery is the other hard case. The line is held low well past a full character, and a normal character must follow correctly once the line is released.

// File: rtl/srx_pkg.sv
package srx_pkg;

   localparam int SRX_MAX_BITS = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP1,
      ST_STOP2,
      ST_BRKWAIT
   } srx_state_e;

   typedef struct packed {
      logic       fin;
      logic       brk;
      logic       par_bad;
      logic       stop_bad;
      logic [7:0] data;
   } srx_result_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout,
   output logic fall
);
   logic [STAGES:0] chain;
   logic            prev_q;

   assign chain[0] = din;

   for (genvar g = 1; g <= STAGES; g++) begin : g_stage
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b1;
         else        q <= chain[g-1];
      end
      assign chain[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain[STAGES];
   end

   assign dout = chain[STAGES];
   assign fall = prev_q & ~chain[STAGES];
endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] divisor,
   input  logic [DIV_W-1:0] offset,
   output logic             sample_stb,
   output logic             bit_end
);
   logic [DIV_W-1:0] cnt;

   assign sample_stb = run && (cnt == offset);
   assign bit_end    = run && (cnt == divisor - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= DIV_W'(1);
      else if (!run)    cnt <= '0;
      else if (bit_end) cnt <= '0;
      else              cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/srx_frame_ctrl.sv
module srx_frame_ctrl
   import srx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable,
   input  logic [1:0]  cfg_width,
   input  logic        cfg_par_en,
   input  logic        cfg_par_even,
   input  logic        cfg_stop2,
   input  logic        line,
   input  logic        fall,
   input  logic        sample_stb,
   input  logic        bit_end,
   output logic        restart,
   output logic        run,
   output srx_result_t result
);
   srx_state_e state;
   logic [2:0] bit_idx;
   logic [2:0] last_idx;
   logic [7:0] shreg;
   logic       par_bit;
   logic       stop1_bit;
   logic       finish;
   logic       first_stop;
   logic       is_break;
   logic       want_par;

   assign last_idx   = {1'b1, cfg_width};
   assign restart    = enable && (state == ST_IDLE) && fall;
   assign run        = enable && (state inside {ST_START, ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2});
   assign finish     = enable && sample_stb &&
                       (((state == ST_STOP1) && !cfg_stop2) || (state == ST_STOP2));
   assign first_stop = (state == ST_STOP2) ? stop1_bit : line;
   assign is_break   = (shreg == 8'h00) && !(cfg_par_en && par_bit) && !first_stop;
   assign want_par   = (^shreg) ^ ~cfg_par_even;

   always_comb begin
      result          = '0;
      result.fin      = finish;
      result.brk      = finish && is_break;
      result.data     = shreg;
      result.par_bad  = finish && !is_break && cfg_par_en && (par_bit != want_par);
      result.stop_bad = finish && (is_break || !line ||
                                   ((state == ST_STOP2) && !stop1_bit));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_idx   <= '0;
         shreg     <= '0;
         par_bit   <= 1'b0;
         stop1_bit <= 1'b1;
      end else if (!enable) begin
         state <= ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (fall) begin
                  state   <= ST_START;
                  bit_idx <= '0;
                  shreg   <= '0;
                  par_bit <= 1'b0;
               end
            end
            ST_START: begin
               if (sample_stb && line) state <= ST_IDLE;
               else if (bit_end)       state <= ST_DATA;
            end
            ST_DATA: begin
               if (sample_stb) shreg[bit_idx] <= line;
               if (bit_end) begin
                  if (bit_idx == last_idx) state <= cfg_par_en ? ST_PARITY : ST_STOP1;
                  else                     bit_idx <= bit_idx + 3'd1;
               end
            end
            ST_PARITY: begin
               if (sample_stb) par_bit <= line;
               if (bit_end)    state   <= ST_STOP1;
            end
            ST_STOP1: begin
               if (finish)          state     <= is_break ? ST_BRKWAIT : ST_IDLE;
               else if (sample_stb) stop1_bit <= line;
               else if (bit_end)    state     <= ST_STOP2;
            end
            ST_STOP2: begin
               if (finish) state <= is_break ? ST_BRKWAIT : ST_IDLE;
            end
            ST_BRKWAIT: begin
               if (line) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
   import srx_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_global,
   input  logic             en_rx,
   input  logic [1:0]       cfg_width,
   input  logic             cfg_par_en,
   input  logic             cfg_par_even,
   input  logic             cfg_stop2,
   input  logic [DIV_W-1:0] cfg_divisor,
   input  logic [DIV_W-1:0] cfg_sample_off,
   input  logic             rxd,
   input  logic             fifo_full,
   output logic [7:0]       out_data,
   output logic             out_wr,
   output logic             ev_parity_err,
   output logic             ev_stop_err,
   output logic             ev_break,
   output logic             ev_overrun
);
   initial begin
      assert (DIV_W >= 3) else $error("serial_rx_engine: DIV_W must be at least 3");
      assert (SYNC_STAGES >= 2) else $error("serial_rx_engine: SYNC_STAGES must be at least 2");
   end

   logic        line;
   logic        fall;
   logic        enable;
   logic        restart;
   logic        run;
   logic        sample_stb;
   logic        bit_end;
   srx_result_t res;

   assign enable = en_global & en_rx;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line), .fall(fall)
   );

   srx_bit_timer #(.DIV_W(DIV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
      .divisor(cfg_divisor), .offset(cfg_sample_off),
      .sample_stb(sample_stb), .bit_end(bit_end)
   );

   srx_frame_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .cfg_width(cfg_width), .cfg_par_en(cfg_par_en),
      .cfg_par_even(cfg_par_even), .cfg_stop2(cfg_stop2),
      .line(line), .fall(fall), .sample_stb(sample_stb), .bit_end(bit_end),
      .restart(restart), .run(run), .result(res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data      <= '0;
         out_wr        <= 1'b0;
         ev_parity_err <= 1'b0;
         ev_stop_err   <= 1'b0;
         ev_break      <= 1'b0;
         ev_overrun    <= 1'b0;
      end else begin
         out_wr        <= res.fin && !res.brk && !fifo_full;
         ev_overrun    <= res.fin && !res.brk && fifo_full;
         ev_parity_err <= res.par_bad;
         ev_stop_err   <= res.stop_bad;
         ev_break      <= res.brk;
         if (res.fin && !res.brk) out_data <= res.data;
      end
   end
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
   input logic clk,
   input logic rst_n,
   input logic en_global,
   input logic en_rx,
   input logic fifo_full,
   input logic out_wr,
   input logic ev_parity_err,
   input logic ev_stop_err,
   input logic ev_break,
   input logic ev_overrun
);
   AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |=> !out_wr);                                             // R2
   AST_PAR_WITH_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      ev_parity_err |-> (out_wr || ev_overrun));                       // R5
   AST_BREAK_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      ev_break |-> (ev_stop_err && !out_wr && !ev_overrun && !ev_parity_err)); // R7
   AST_WR_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |-> !$past(fifo_full));                                   // R8
   AST_WR_OVR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_wr && ev_overrun));                                        // R8
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_global && en_rx) |->
         !(out_wr || ev_overrun || ev_parity_err || ev_stop_err || ev_break)); // R9
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !(out_wr || ev_overrun || ev_break));                 // R1
endmodule

bind serial_rx_engine srx_checker u_srx_chk (
   .clk(clk), .rst_n(rst_n), .en_global(en_global), .en_rx(en_rx),
   .fifo_full(fifo_full), .out_wr(out_wr), .ev_parity_err(ev_parity_err),
   .ev_stop_err(ev_stop_err), .ev_break(ev_break), .ev_overrun(ev_overrun)
);

// File: tb/serial_rx_engine_test.sv
`timescale 1ns/1ps
module serial_rx_engine_test;
   localparam int DIV_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en_global = 1'b1, en_rx = 1'b1;
   logic [1:0]       cfg_width = 2'd3;
   logic             cfg_par_en = 1'b0, cfg_par_even = 1'b1, cfg_stop2 = 1'b0;
   logic [DIV_W-1:0] cfg_divisor = 16'd16, cfg_sample_off = 16'd8;
   logic             rxd = 1'b1, fifo_full = 1'b0;
   logic [7:0]       out_data;
   logic             out_wr, ev_parity_err, ev_stop_err, ev_break, ev_overrun;

   int n_tests = 0, n_fail = 0, cyc = 0;
   int c_wr = 0, c_par = 0, c_stop = 0, c_brk = 0, c_ovr = 0;
   logic [7:0] last_data = 8'h00;
   bit done = 1'b0;

   always #4 clk = ~clk;

   serial_rx_engine #(.DIV_W(DIV_W)) uut (.*);

   always @(negedge clk) begin
      if (out_wr) begin c_wr++; last_data = out_data; end
      if (ev_parity_err) c_par++;
      if (ev_stop_err)   c_stop++;
      if (ev_break)      c_brk++;
      if (ev_overrun)    c_ovr++;
   end

   task automatic summary();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         n_fail++;
         $display("FAIL watchdog R1..: run hung, actual %0d cycles expected < 190000", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] wmask(input logic [1:0] w);
      return 8'hFF >> (3 - w);
   endfunction

   function automatic logic par_of(input logic [7:0] d, input logic even);
      return (^d) ^ ~even;
   endfunction

   task automatic hold(input logic v, input int n);
      rxd = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit bad_stop2);
      int div = int'(cfg_divisor);
      logic [7:0] md = d & wmask(cfg_width);
      hold(1'b0, div);
      for (int i = 0; i < int'(cfg_width) + 5; i++) hold(md[i], div);
      if (cfg_par_en) hold(par_of(md, cfg_par_even) ^ bad_par, div);
      hold(!bad_stop, div);
      if (cfg_stop2) hold(!bad_stop2, div);
      hold(1'b1, 3 * div);
   endtask

   int s_wr, s_par, s_stop, s_brk, s_ovr;
   task automatic snap();
      s_wr = c_wr; s_par = c_par; s_stop = c_stop; s_brk = c_brk; s_ovr = c_ovr;
   endtask

   task automatic expect_out(input string req, input int e_wr, input logic [7:0] e_data,
                             input int e_par, input int e_stop, input int e_brk, input int e_ovr);
      chk(c_wr - s_wr == e_wr, req, "write count", c_wr - s_wr, e_wr);
      if (e_wr != 0) chk(last_data == e_data, req, "data", last_data, e_data);
      chk(c_par - s_par == e_par, req, "parity events", c_par - s_par, e_par);
      chk(c_stop - s_stop == e_stop, req, "stop events", c_stop - s_stop, e_stop);
      chk(c_brk - s_brk == e_brk, req, "break events", c_brk - s_brk, e_brk);
      chk(c_ovr - s_ovr == e_ovr, req, "overrun events", c_ovr - s_ovr, e_ovr);
   endtask

   initial begin
      logic [7:0] d;
      void'($urandom(32'd20417));
      repeat (3) @(negedge clk);
      // R1: outputs quiet in reset and just after
      chk(!out_wr && !ev_break && !ev_overrun && !ev_stop_err && !ev_parity_err,
          "R1", "outputs in reset", {out_wr, ev_break, ev_overrun}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_wr && !ev_break && !ev_overrun && !ev_stop_err && !ev_parity_err,
          "R1", "outputs after reset", {out_wr, ev_break, ev_overrun}, 0);

      // R2 R3 R5 R6: random legal frames and formats
      for (int k = 0; k < 40; k++) begin
         cfg_divisor    = 16'(8 + ($urandom % 33));
         cfg_sample_off = cfg_divisor / 2;
         cfg_width      = 2'($urandom % 4);
         cfg_par_en     = 1'($urandom % 2);
         cfg_par_even   = 1'($urandom % 2);
         cfg_stop2      = 1'($urandom % 2);
         d = 8'($urandom);
         snap();
         send_frame(d, 1'b0, 1'b0, 1'b0);
         expect_out("R2", 1, d & wmask(cfg_width), 0, 0, 0, 0);
      end

      // R2: 5-bit width keeps upper bits zero
      cfg_divisor = 16'd16; cfg_sample_off = 16'd8; cfg_width = 2'd0;
      cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
      snap(); send_frame(8'hFF, 1'b0, 1'b0, 1'b0);
      expect_out("R2", 1, 8'h1F, 0, 0, 0, 0);

      // R5: parity mismatch, even and odd sense
      cfg_width = 2'd3; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
      snap(); send_frame(8'h5A, 1'b1, 1'b0, 1'b0);
      expect_out("R5", 1, 8'h5A, 1, 0, 0, 0);
      cfg_par_even = 1'b0;
      snap(); send_frame(8'h81, 1'b1, 1'b0, 1'b0);
      expect_out("R5", 1, 8'h81, 1, 0, 0, 0);

      // R6: bad single stop, bad second stop
      cfg_par_en = 1'b0;
      snap(); send_frame(8'hA5, 1'b0, 1'b1, 1'b0);
      expect_out("R6", 1, 8'hA5, 0, 1, 0, 0);
      cfg_stop2 = 1'b1;
      snap(); send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
      expect_out("R6", 1, 8'h3C, 0, 1, 0, 0);
      cfg_stop2 = 1'b0;

      // R8: queue full drops the character
      fifo_full = 1'b1;
      snap(); send_frame(8'h77, 1'b0, 1'b0, 1'b0);
      expect_out("R8", 0, 8'h00, 0, 0, 0, 1);
      fifo_full = 1'b0;

      // R7: long low line is a break, then recovery
      cfg_par_en = 1'b1; cfg_par_even = 1'b0;
      snap(); hold(1'b0, 16 * 16); hold(1'b1, 48);
      expect_out("R7", 0, 8'h00, 0, 1, 1, 0);
      snap(); send_frame(8'hC3, 1'b0, 1'b0, 1'b0);
      expect_out("R7", 1, 8'hC3, 0, 0, 0, 0);
      cfg_par_en = 1'b0;

      // R4: short glitch aborts, next frame fine
      snap(); hold(1'b0, 3); hold(1'b1, 48);
      expect_out("R4", 0, 8'h00, 0, 0, 0, 0);
      snap(); send_frame(8'h96, 1'b0, 1'b0, 1'b0);
      expect_out("R4", 1, 8'h96, 0, 0, 0, 0);

      // R9: either enable low ignores a frame
      en_rx = 1'b0;
      snap(); send_frame(8'h42, 1'b0, 1'b0, 1'b0);
      expect_out("R9", 0, 8'h00, 0, 0, 0, 0);
      en_rx = 1'b1; en_global = 1'b0;
      snap(); send_frame(8'h24, 1'b0, 1'b0, 1'b0);
      expect_out("R9", 0, 8'h00, 0, 0, 0, 0);
      en_global = 1'b1;

      // R3: half-bit split pattern; offset picks first or second half
      cfg_divisor = 16'd32;
      for (int pass = 0; pass < 2; pass++) begin
         cfg_sample_off = (pass == 0) ? 16'd6 : 16'd26;
         d = 8'hB4;
         snap();
         hold(1'b0, 32);
         for (int i = 0; i < 8; i++) begin hold(d[i], 16); hold(~d[i], 16); end
         hold(1'b1, 32); hold(1'b1, 96);
         expect_out("R3", 1, (pass == 0) ? d : ~d, 0, 0, 0, 0);
      end

      summary();
   end
endmodule